// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves one jump-class instruction per cycle and tells the fetch stage where to go next. Each valid request carries an 8-bit opcode, the destination and source operand values, a 32-bit immediate, a 16-bit signed offset and the current program counter. One clock later the unit presents the next program counter together with four outcome flags: whether the branch was taken, whether a call or an exit is requested, whether the opcode is illegal, and whether the chosen next address leaves the program space.

There is only one branch target. A true condition moves the counter by the signed offset relative to the following instruction; a false condition simply falls through. Two compare classes exist: one compares the full 64-bit operands and the other compares only their low 32 bits. Conditions cover equality, inequality, bit test, four unsigned orderings, four signed orderings and an unconditional jump. The call target itself and the register file lie outside this unit; a call or exit is only flagged.

Top module: `jump_resolve_unit`

## Requirements
- R1: Results are registered: out_valid rises exactly one clock after a cycle with in_valid high, and in any cycle with out_valid low the flags taken, call_req, exit_req, illegal and fault are all 0.
- R2: opcode[2:0] is the class (5 = 64-bit compare class, 6 = 32-bit compare class) and opcode[7:4] the condition; opcode[3] = 1 selects src_val as second operand, opcode[3] = 0 selects imm sign-extended to 64 bits.
- R3: Condition 1 is taken when the operands are equal, condition 5 when they differ, condition 4 when their bitwise AND is nonzero.
- R4: Unsigned conditions: 2 taken on greater, 3 on greater-or-equal, 10 on less, 11 on less-or-equal.
- R5: Signed two's-complement conditions: 6 taken on greater, 7 on greater-or-equal, 12 on less, 13 on less-or-equal.
- R6: In class 6 only bits 31:0 of both operands are compared, with bit 31 as sign for signed conditions; upper bits have no effect.
- R7: Condition 0 in class 5 is always taken.
- R8: When taken, next_pc = pc + 1 + sign-extended offset; otherwise next_pc = pc + 1.
- R9: In class 5, condition 8 sets call_req and condition 9 sets exit_req; both leave taken at 0 and next_pc at pc + 1.
- R10: illegal is 1, with taken, call_req and exit_req 0 and next_pc = pc + 1, for conditions 0, 8 or 9 in class 6, for conditions 14 and 15 in either class, and for any class other than 5 or 6.
- R11: If the selected next address is below 0 or at or above DEPTH (4096), fault is 1 and next_pc equals the request's pc.
- R12: While rst is high and after it, until the first request, out_valid, next_pc and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 8 | Condition, source select and class |
| dst_val | input | 64 | First compare operand |
| src_val | input | 64 | Register second operand |
| imm | input | 32 | Immediate second operand |
| offset | input | 16 | Signed branch offset in instructions |
| pc | input | 12 | Address of the branch instruction |
| out_valid | output | 1 | Result present |
| next_pc | output | 12 | Address of the next instruction |
| taken | output | 1 | Condition held and the branch moves the counter |
| call_req | output | 1 | Call requested |
| exit_req | output | 1 | Exit requested |
| illegal | output | 1 | Opcode not a legal jump |
| fault | output | 1 | Selected address outside program space |

## Verification
The unit keeps no state between requests beyond its output register, so any wrong decode or compare shows at the ports on the very next clock as a wrong taken flag or next_pc for that request alone. A mix-up between the signed and unsigned paths appears only when operand sign bits differ, and a leak of upper bits into the 32-bit class appears only when bits 63:32 differ from the low half, so the stimulus deliberately sets those patterns. Address faults show only at the two ends of the program space, which are driven directly.

// File: rtl/jru_pkg.sv
package jru_pkg;
  localparam logic [2:0] CLS_JMP64 = 3'd5;
  localparam logic [2:0] CLS_JMP32 = 3'd6;

  typedef enum logic [3:0] {
    C_ALWAYS = 4'h0, C_EQ  = 4'h1, C_UGT = 4'h2, C_UGE = 4'h3,
    C_TEST   = 4'h4, C_NE  = 4'h5, C_SGT = 4'h6, C_SGE = 4'h7,
    C_CALL   = 4'h8, C_EXIT = 4'h9, C_ULT = 4'ha, C_ULE = 4'hb,
    C_SLT    = 4'hc, C_SLE = 4'hd, C_RSV0 = 4'he, C_RSV1 = 4'hf
  } jcond_e;

  typedef struct packed {
    logic   wide;
    logic   use_reg;
    jcond_e cond;
    logic   legal;
    logic   is_call;
    logic   is_exit;
  } jdec_t;
endpackage

// File: rtl/jru_decode.sv
module jru_decode
  import jru_pkg::*;
(
  input  logic [7:0] opcode,
  output jdec_t      dec
);
  logic [2:0] cls;
  jcond_e     cnd;
  logic       cls_ok;
  logic       cnd_ok;

  assign cls = opcode[2:0];
  assign cnd = jcond_e'(opcode[7:4]);

  always_comb begin
    cls_ok = (cls == CLS_JMP64) || (cls == CLS_JMP32);
    case (cnd)
      C_RSV0, C_RSV1:         cnd_ok = 1'b0;
      C_ALWAYS, C_CALL, C_EXIT: cnd_ok = (cls == CLS_JMP64);
      default:                cnd_ok = 1'b1;
    endcase
  end

  always_comb begin
    dec.wide    = (cls == CLS_JMP64);
    dec.use_reg = opcode[3];
    dec.cond    = cnd;
    dec.legal   = cls_ok && cnd_ok;
    dec.is_call = cls_ok && cnd_ok && (cnd == C_CALL);
    dec.is_exit = cls_ok && cnd_ok && (cnd == C_EXIT);
  end
endmodule

// File: rtl/jru_cmp_core.sv
module jru_cmp_core
  import jru_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  jcond_e       cond,
  output logic         hit
);
  logic eq, ult, slt;

  assign eq  = (a == b);
  assign ult = (a < b);
  assign slt = ($signed(a) < $signed(b));

  always_comb begin
    case (cond)
      C_ALWAYS: hit = 1'b1;
      C_EQ:     hit = eq;
      C_NE:     hit = !eq;
      C_TEST:   hit = |(a & b);
      C_UGT:    hit = !ult && !eq;
      C_UGE:    hit = !ult;
      C_ULT:    hit = ult;
      C_ULE:    hit = ult || eq;
      C_SGT:    hit = !slt && !eq;
      C_SGE:    hit = !slt;
      C_SLT:    hit = slt;
      C_SLE:    hit = slt || eq;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/jru_target.sv
module jru_target #(
  parameter int PCW   = 12,
  parameter int OFFW  = 16,
  parameter int DEPTH = 4096
) (
  input  logic [PCW-1:0]  pc,
  input  logic [OFFW-1:0] offset,
  input  logic            take,
  output logic [PCW-1:0]  next_pc,
  output logic            fault
);
  localparam int SW = ((PCW > OFFW) ? PCW : OFFW) + 2;

  logic signed [SW-1:0] pc_s, off_s, seq_s, sel_s;

  always_comb begin
    pc_s  = $signed({{(SW-PCW){1'b0}}, pc});
    off_s = $signed({{(SW-OFFW){offset[OFFW-1]}}, offset});
    seq_s = pc_s + SW'(1);
    sel_s = take ? (seq_s + off_s) : seq_s;
    fault = (sel_s < 0) || (sel_s >= SW'(DEPTH));
    next_pc = fault ? pc : sel_s[PCW-1:0];
  end
endmodule

// File: rtl/jump_resolve_unit.sv
module jump_resolve_unit
  import jru_pkg::*;
#(
  parameter int DW    = 64,
  parameter int NW    = 32,
  parameter int IMMW  = 32,
  parameter int OFFW  = 16,
  parameter int DEPTH = 4096,
  parameter int PCW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      opcode,
  input  logic [DW-1:0]   dst_val,
  input  logic [DW-1:0]   src_val,
  input  logic [IMMW-1:0] imm,
  input  logic [OFFW-1:0] offset,
  input  logic [PCW-1:0]  pc,
  output logic            out_valid,
  output logic [PCW-1:0]  next_pc,
  output logic            taken,
  output logic            call_req,
  output logic            exit_req,
  output logic            illegal,
  output logic            fault
);
  localparam int NCMP = 2;

  jdec_t         dec;
  logic [DW-1:0] opb;
  logic [NCMP-1:0] hit;
  logic          take;
  logic [PCW-1:0] tgt_pc;
  logic          tgt_fault;

  jru_decode u_dec (.opcode(opcode), .dec(dec));

  assign opb = dec.use_reg ? src_val : {{(DW-IMMW){imm[IMMW-1]}}, imm};

  // index 0: narrow compare, index 1: full-width compare
  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    localparam int CW = (g == 0) ? NW : DW;
    jru_cmp_core #(.W(CW)) u_core (
      .a    (dst_val[CW-1:0]),
      .b    (opb[CW-1:0]),
      .cond (dec.cond),
      .hit  (hit[g])
    );
  end

  assign take = dec.legal && !dec.is_call && !dec.is_exit &&
                (dec.wide ? hit[1] : hit[0]);

  jru_target #(.PCW(PCW), .OFFW(OFFW), .DEPTH(DEPTH)) u_tgt (
    .pc      (pc),
    .offset  (offset),
    .take    (take),
    .next_pc (tgt_pc),
    .fault   (tgt_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      call_req  <= 1'b0;
      exit_req  <= 1'b0;
      illegal   <= 1'b0;
      fault     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid && take;
      call_req  <= in_valid && dec.is_call;
      exit_req  <= in_valid && dec.is_exit;
      illegal   <= in_valid && !dec.legal;
      fault     <= in_valid && tgt_fault;
      if (in_valid) next_pc <= tgt_pc;
    end
  end
endmodule

// File: rtl/jru_checker.sv
module jru_checker #(
  parameter int PCW = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [7:0]     opcode,
  input logic [PCW-1:0] pc,
  input logic           out_valid,
  input logic [PCW-1:0] next_pc,
  input logic           taken,
  input logic           call_req,
  input logic           exit_req,
  input logic           illegal,
  input logic           fault
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !taken && !call_req && !exit_req && !illegal && !fault));
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({taken, call_req, exit_req, illegal}));
  assert_narrow_special_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[2:0] == 3'd6 &&
     (opcode[7:4] == 4'h0 || opcode[7:4] == 4'h8 || opcode[7:4] == 4'h9)) |=> illegal);
  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!fault || next_pc == $past(pc)));
  assert_fallthrough_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (taken || fault || next_pc == $past(pc) + PCW'(1)));
endmodule

bind jump_resolve_unit jru_checker #(.PCW(PCW)) u_jru_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .pc(pc),
  .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
  .call_req(call_req), .exit_req(exit_req), .illegal(illegal), .fault(fault)
);

// File: tb/test_jump_resolve_unit.sv
`timescale 1ns/1ps
module test_jump_resolve_unit;
  localparam int PCW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] opcode = '0;
  logic [63:0] dst_val = '0, src_val = '0;
  logic [31:0] imm = '0;
  logic [15:0] offset = '0;
  logic [PCW-1:0] pc = '0;
  logic out_valid, taken, call_req, exit_req, illegal, fault;
  logic [PCW-1:0] next_pc;

  always #5 clk = ~clk;

  jump_resolve_unit i_jump_resolve_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset), .pc(pc),
    .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
    .call_req(call_req), .exit_req(exit_req), .illegal(illegal), .fault(fault)
  );

  typedef struct packed {
    logic [PCW-1:0] np;
    logic tk, cl, ex, il, ft;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic exp_t model(input logic [7:0] op, input logic [63:0] d,
      input logic [63:0] s, input logic [31:0] i, input logic [15:0] off,
      input logic [PCW-1:0] p);
    exp_t e;
    logic [63:0] b, ua, ub;
    longint sa, sb, t;
    logic [3:0] c;
    e = '0;
    c = op[7:4];
    b = op[3] ? s : {{32{i[31]}}, i};
    if (op[2:0] == 3'd5) begin
      ua = d; ub = b; sa = $signed(d); sb = $signed(b);
    end else begin
      ua = {32'd0, d[31:0]}; ub = {32'd0, b[31:0]};
      sa = $signed({{32{d[31]}}, d[31:0]}); sb = $signed({{32{b[31]}}, b[31:0]});
    end
    if (op[2:0] != 3'd5 && op[2:0] != 3'd6) e.il = 1;
    else if (c >= 4'he) e.il = 1;
    else if (op[2:0] == 3'd6 && (c == 4'h0 || c == 4'h8 || c == 4'h9)) e.il = 1;
    else begin
      case (c)
        4'h0: e.tk = 1;
        4'h1: e.tk = (ua == ub);
        4'h5: e.tk = (ua != ub);
        4'h4: e.tk = ((ua & ub) != 0);
        4'h2: e.tk = (ua > ub);
        4'h3: e.tk = (ua >= ub);
        4'ha: e.tk = (ua < ub);
        4'hb: e.tk = (ua <= ub);
        4'h6: e.tk = (sa > sb);
        4'h7: e.tk = (sa >= sb);
        4'hc: e.tk = (sa < sb);
        4'hd: e.tk = (sa <= sb);
        4'h8: e.cl = 1;
        4'h9: e.ex = 1;
        default: ;
      endcase
    end
    t = longint'(p) + 1;
    if (e.tk) t = t + longint'($signed(off));
    e.ft = (t < 0) || (t >= 4096);
    e.np = e.ft ? p : t[PCW-1:0];
    return e;
  endfunction

  task automatic send(input string tag, input logic [7:0] op, input logic [63:0] d,
      input logic [63:0] s, input logic [31:0] i, input logic [15:0] off,
      input logic [PCW-1:0] p);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; dst_val = d; src_val = s; imm = i;
    offset = off; pc = p;
    exp_q.push_back(model(op, d, s, i, off, p));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected result: out_valid=1 expected 0");
        end else begin
          exp_t e, a;
          string tg;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          a = {next_pc, taken, call_req, exit_req, illegal, fault};
          if (a !== e) begin
            errors++;
            $display("FAIL %s np/tk/cl/ex/il/ft actual %h/%b%b%b%b%b expected %h/%b%b%b%b%b",
              tg, a.np, a.tk, a.cl, a.ex, a.il, a.ft, e.np, e.tk, e.cl, e.ex, e.il, e.ft);
          end
        end
      end else if (taken || call_req || exit_req || illegal || fault) begin
        checks++;
        errors++;
        $display("FAIL R1 idle flags actual %b%b%b%b%b expected 00000",
          taken, call_req, exit_req, illegal, fault);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] lf;
    lf = 64'h1234_5678_9abc_def1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || next_pc !== 0 || taken !== 0 || call_req !== 0 ||
        exit_req !== 0 || illegal !== 0 || fault !== 0) begin
      errors++;
      $display("FAIL R12 reset state actual v=%b np=%h expected v=0 np=000", out_valid, next_pc);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || next_pc !== 0) begin
      errors++;
      $display("FAIL R12 after reset actual v=%b np=%h expected v=0 np=000", out_valid, next_pc);
    end

    // R3 equality / bit test, register and immediate sources (R2)
    send("R3 eq reg",   8'h1d, 64'd77, 64'd77, 32'd0, 16'd10, 12'd100);
    send("R3 eq imm",   8'h15, 64'hffff_ffff_ffff_fffe, 64'd0, 32'hffff_fffe, 16'd5, 12'd20);
    send("R3 ne false", 8'h5d, 64'd9, 64'd9, 32'd0, 16'd3, 12'd30);
    send("R3 test hit", 8'h4d, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 32'd0, 16'd2, 12'd40);
    send("R3 test miss",8'h45, 64'h0f0, 64'd0, 32'h00f, 16'd2, 12'd40);
    // R2 immediate sign extension compared against zero-extended value
    send("R2 imm sext", 8'h15, 64'h0000_0000_ffff_ffff, 64'd0, 32'hffff_ffff, 16'd1, 12'd5);
    // R4 unsigned vs R5 signed with differing sign bits
    send("R4 ugt",  8'h2d, 64'hffff_ffff_ffff_ffff, 64'd1, 32'd0, 16'd4, 12'd50);
    send("R5 sgt",  8'h6d, 64'hffff_ffff_ffff_ffff, 64'd1, 32'd0, 16'd4, 12'd50);
    send("R4 ult",  8'had, 64'd1, 64'hffff_ffff_ffff_ffff, 32'd0, 16'd4, 12'd50);
    send("R5 slt",  8'hcd, 64'd1, 64'hffff_ffff_ffff_ffff, 32'd0, 16'd4, 12'd50);
    send("R4 uge eq", 8'h3d, 64'd5, 64'd5, 32'd0, 16'd4, 12'd60);
    send("R4 ule eq", 8'hbd, 64'd5, 64'd5, 32'd0, 16'd4, 12'd60);
    send("R5 sge eq", 8'h7d, 64'd5, 64'd5, 32'd0, 16'd4, 12'd60);
    send("R5 sle",    8'hdd, 64'hffff_ffff_ffff_fff0, 64'd3, 32'd0, 16'd4, 12'd60);
    // R6 narrow class ignores upper bits and uses bit 31 as sign
    send("R6 eq low", 8'h1e, 64'hdead_0000_0000_0042, 64'hbeef_0000_0000_0042, 32'd0, 16'd7, 12'd70);
    send("R6 sgt low",8'h6e, 64'h7fff_ffff_8000_0000, 64'h8000_0000_0000_0001, 32'd0, 16'd7, 12'd70);
    send("R6 ugt low",8'h2e, 64'h0000_0000_8000_0000, 64'hffff_ffff_0000_0001, 32'd0, 16'd7, 12'd70);
    send("R6 wide ne",8'h5d, 64'hdead_0000_0000_0042, 64'hbeef_0000_0000_0042, 32'd0, 16'd7, 12'd70);
    // R7 unconditional, R8 backward offset
    send("R7 always", 8'h05, 64'd0, 64'd0, 32'd0, 16'hfff6, 12'd200);
    send("R8 back",   8'h1d, 64'd1, 64'd1, 32'd0, 16'hff00, 12'd1000);
    // R9 call/exit
    send("R9 call",   8'h85, 64'd0, 64'd0, 32'd0, 16'd50, 12'd300);
    send("R9 exit",   8'h95, 64'd0, 64'd0, 32'd0, 16'd50, 12'd301);
    // R10 illegal cases
    send("R10 ja32",   8'h06, 64'd0, 64'd0, 32'd0, 16'd9, 12'd400);
    send("R10 call32", 8'h86, 64'd0, 64'd0, 32'd0, 16'd9, 12'd400);
    send("R10 exit32", 8'h96, 64'd0, 64'd0, 32'd0, 16'd9, 12'd400);
    send("R10 rsv",    8'he5, 64'd0, 64'd0, 32'd0, 16'd9, 12'd400);
    send("R10 class4", 8'h14, 64'd3, 64'd3, 32'd3, 16'd9, 12'd400);
    idle(2);
    // R11 faults at both ends
    send("R11 top fall", 8'h5d, 64'd1, 64'd1, 32'd0, 16'd0, 12'd4095);
    send("R11 over",     8'h05, 64'd0, 64'd0, 32'd0, 16'd100, 12'd4000);
    send("R11 under",    8'h05, 64'd0, 64'd0, 32'd0, 16'hff00, 12'd10);
    send("R11 edge ok",  8'h05, 64'd0, 64'd0, 32'd0, 16'd94, 12'd4000);
    send("R11 zero ok",  8'h05, 64'd0, 64'd0, 32'd0, 16'hfff5, 12'd10);
    idle(1);
    // mixed pseudo-random sweep
    for (int n = 0; n < 300; n++) begin
      logic [7:0] op;
      logic [63:0] d, s;
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      lf = lf * 64'd6364136223846793005 + 64'd1442695040888963407;
      op = {lf[7:4], lf[3], 2'b10, lf[8]};
      if (op[2:0] == 3'd4) op[2:0] = 3'd5;
      d = lf[9] ? lf : {32'hffff_ffff, lf[63:32]};
      s = lf[10] ? d ^ {63'd0, lf[11]} : {lf[31:0], lf[63:32]};
      send("R8 sweep", op, d, s, lf[43:12], {{6{lf[44]}}, lf[53:44]}, lf[63:52]);
      if (lf[20] && lf[21]) idle(1);
    end
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 results missing actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule